// File: doc/BRIEF.md
# Pixel Shift and Mask Assist Unit

This block helps software move 4-bit-per-pixel bitmap data to screen positions that do not fall on a word boundary. A 32-bit word holds eight pixels. Software writes a source word, then writes a pixel shift count. It can then read three results: the word shifted right by whole pixels, the pixels that dropped off the right edge (moved up to the top of a word), and a transparency mask of the shifted word. A separate mask-generator register turns any pixel word written to it into a per-pixel mask. In that mask each nibble is 0xF where the pixel is nonzero and 0x0 where it is zero.

Access is through a simple synchronous register port with address, write enable, write data, read enable and read data. Byte offsets within the register area: 0x18 shift data (read/write), 0x1C shift count (write-only), 0x20 shifted mask (read-only), 0x24 spill (read-only), 0x28 mask generator (read/write). An access matches only when the address equals one of these offsets exactly. A foreground sprite is usually placed by shifting it, ANDing the background with the inverted mask, and ORing in the shifted pixels. The spill word is then carried into the next word to the right.

Top module: `pxa_unit`

## Requirements
- R1: After a synchronous active-high reset the source word, the shift count and the mask-generator input are zero, so reads of 0x18, 0x20, 0x24 and 0x28 all return zero.
- R2: Read data is registered. A read request in one cycle shows its value on rdData after the next rising edge. After any cycle without a read request, rdData is zero.
- R3: A write to 0x18 loads the source word and sets the shift count to zero. A read of 0x18 returns the shifted word, which equals the source while the count is zero.
- R4: A write to 0x1C sets the shift count from wrData bits 2:0 and ignores bits 31:3.
- R5: The shifted word equals the source shifted right by 4 × count bits (0 to 7 pixels). Vacated pixel positions on the left are zero.
- R6: Reading 0x24 returns the spill word. It holds the count rightmost source pixels, placed in the count topmost pixel positions, with all other bits zero. With a count of 0 it reads zero.
- R7: Reading 0x20 returns the mask of the shifted word. Nibble i is 0xF when pixel i of the shifted word is nonzero and 0x0 otherwise.
- R8: Writing a word to 0x28 and reading 0x28 returns that word's mask, with the same nibble rule as R7.
- R9: Writes to 0x20 and 0x24 change nothing. Reads of 0x1C and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte offset |
| wrEn | input | 1 | Write request this cycle |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read request this cycle |
| rdData | output | 32 | Read data, valid one cycle after rdEn |

## Verification
The source word and the count are the only state behind three read results. A wrong value in either appears at the next read of 0x18, 0x20 or 0x24, which is two cycles after the write that caused it. A count that is not cleared by a source write shows up as a shifted word that differs from the source. A count built from the wrong bits shows up as a wrong shift distance when high address-like bits are set. A broken spill or mask path leaves the shifted word correct but spoils the other two reads. For this reason each vector checks all three reads.

// File: rtl/pxa_pkg.sv
package pxa_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SHIFT,
    SEL_SMASK,
    SEL_SPILL,
    SEL_MGEN
  } rdSelT;

  typedef struct packed {
    logic  loadSrc;
    logic  loadCnt;
    logic  loadMgen;
    rdSelT rdSel;
  } pxaStrobesT;

  localparam logic [7:0] OFF_SHIFT = 8'h18;
  localparam logic [7:0] OFF_COUNT = 8'h1C;
  localparam logic [7:0] OFF_SMASK = 8'h20;
  localparam logic [7:0] OFF_SPILL = 8'h24;
  localparam logic [7:0] OFF_MGEN  = 8'h28;

endpackage

// File: rtl/pxa_maskgen.sv
module pxa_maskgen #(
  parameter int DATA_W = 32,
  parameter int PIX_W  = 4
) (
  input  logic [DATA_W-1:0] pixIn,
  output logic [DATA_W-1:0] maskOut
);
  localparam int NPIX = DATA_W / PIX_W;

  for (genvar i = 0; i < NPIX; i++) begin : g_pix
    assign maskOut[i*PIX_W +: PIX_W] = {PIX_W{|pixIn[i*PIX_W +: PIX_W]}};
  end
endmodule

// File: rtl/pxa_ctrl.sv
module pxa_ctrl
  import pxa_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output pxaStrobesT        strobes
);
  localparam logic [ADDR_W-1:0] A_SHIFT = ADDR_W'(OFF_SHIFT);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_SMASK = ADDR_W'(OFF_SMASK);
  localparam logic [ADDR_W-1:0] A_SPILL = ADDR_W'(OFF_SPILL);
  localparam logic [ADDR_W-1:0] A_MGEN  = ADDR_W'(OFF_MGEN);

  always_comb begin
    strobes          = '0;
    strobes.rdSel    = SEL_NONE;
    strobes.loadSrc  = wrEn && (addr == A_SHIFT);
    strobes.loadCnt  = wrEn && (addr == A_COUNT);
    strobes.loadMgen = wrEn && (addr == A_MGEN);
    if (rdEn) begin
      unique case (addr)
        A_SHIFT: strobes.rdSel = SEL_SHIFT;
        A_SMASK: strobes.rdSel = SEL_SMASK;
        A_SPILL: strobes.rdSel = SEL_SPILL;
        A_MGEN:  strobes.rdSel = SEL_MGEN;
        default: strobes.rdSel = SEL_NONE;
      endcase
    end
  end

  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.loadSrc, strobes.loadCnt, strobes.loadMgen}));

endmodule

// File: rtl/pxa_datapath.sv
module pxa_datapath
  import pxa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PIX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  pxaStrobesT        strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int NPIX  = DATA_W / PIX_W;
  localparam int CNT_W = $clog2(NPIX);

  logic [DATA_W-1:0] srcQ;
  logic [CNT_W-1:0]  cntQ;
  logic [DATA_W-1:0] mgenQ;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] spill;
  logic [DATA_W-1:0] smask;
  logic [DATA_W-1:0] gmask;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      srcQ  <= '0;
      cntQ  <= '0;
      mgenQ <= '0;
    end else begin
      if (strobes.loadSrc) begin
        srcQ <= wrData;
        cntQ <= '0;
      end else if (strobes.loadCnt) begin
        cntQ <= wrData[CNT_W-1:0];
      end
      if (strobes.loadMgen) mgenQ <= wrData;
    end
  end

  always_comb begin
    shifted = srcQ >> (int'(cntQ) * PIX_W);
    if (cntQ == '0) spill = '0;
    else            spill = srcQ << (PIX_W * (NPIX - int'(cntQ)));
  end

  pxa_maskgen #(.DATA_W(DATA_W), .PIX_W(PIX_W)) u_smask (
    .pixIn(shifted), .maskOut(smask));
  pxa_maskgen #(.DATA_W(DATA_W), .PIX_W(PIX_W)) u_gmask (
    .pixIn(mgenQ), .maskOut(gmask));

  always_comb begin
    unique case (strobes.rdSel)
      SEL_SHIFT: rdNext = shifted;
      SEL_SMASK: rdNext = smask;
      SEL_SPILL: rdNext = spill;
      SEL_MGEN:  rdNext = gmask;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else     rdData <= rdNext;
  end

  // R3
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.loadSrc |=> (cntQ == '0));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.loadSrc && !strobes.loadCnt) |=> $stable(cntQ));

  // R6
  rot_identity_chk: assert property (@(posedge clk) disable iff (rst)
    (cntQ != '0) |->
      (((spill >> (PIX_W * (NPIX - int'(cntQ)))) |
        (shifted << (PIX_W * int'(cntQ)))) == srcQ));

endmodule

// File: rtl/pxa_unit.sv
module pxa_unit
  import pxa_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PIX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData
);
  pxaStrobesT strobes;

  pxa_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .strobes(strobes));

  pxa_datapath #(.DATA_W(DATA_W), .PIX_W(PIX_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .wrData(wrData),
    .rdData(rdData));

  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> (rdData == '0));

endmodule

// File: tb/pxa_unit_tb_top.sv
module pxa_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pxa_unit dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData));

  localparam int NV = 7;
  localparam logic [31:0] V_SRC[NV] = '{32'h12345678, 32'h12345678, 32'h12345678,
    32'h0407000F, 32'hA0000000, 32'hFEDCBA98, 32'h10203040};
  localparam logic [31:0] V_CNT[NV] = '{32'h0, 32'h2, 32'h285, 32'h1, 32'h7,
    32'hFFFF_FFF4, 32'h3};
  localparam logic [31:0] V_SHF[NV] = '{32'h12345678, 32'h00123456, 32'h00000123,
    32'h00407000, 32'h0000000A, 32'h0000FEDC, 32'h00010203};
  localparam logic [31:0] V_SPL[NV] = '{32'h00000000, 32'h78000000, 32'h45678000,
    32'hF0000000, 32'h00000000, 32'hBA980000, 32'h04000000};
  localparam logic [31:0] V_MSK[NV] = '{32'hFFFFFFFF, 32'h00FFFFFF, 32'h00000FFF,
    32'h00F0F000, 32'h0000000F, 32'h0000FFFF, 32'h000F0F0F};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h18, v); check("R1 shift", v, 32'h0);
    rd(8'h20, v); check("R1 smask", v, 32'h0);
    rd(8'h24, v); check("R1 spill", v, 32'h0);
    rd(8'h28, v); check("R1 mgen", v, 32'h0);

    // R5 R6 R7 R4 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(8'h18, V_SRC[i]);
      wr(8'h1C, V_CNT[i]);
      rd(8'h18, v); check("R5 shifted", v, V_SHF[i]);
      rd(8'h24, v); check("R6 spill", v, V_SPL[i]);
      rd(8'h20, v); check("R7 smask", v, V_MSK[i]);
    end

    // R2 idle cycle after a read gives zero
    @(negedge clk);
    check("R2 idle", rdData, 32'h0);

    // R3 source write clears the count
    wr(8'h1C, 32'h5);
    wr(8'h18, 32'hCAFE1234);
    rd(8'h18, v); check("R3 count cleared", v, 32'hCAFE1234);
    rd(8'h24, v); check("R3 spill zero", v, 32'h0);

    // R8 mask generator
    wr(8'h28, 32'h00000001); rd(8'h28, v); check("R8 mgen 1", v, 32'h0000000F);
    wr(8'h28, 32'h0407000F); rd(8'h28, v); check("R8 mgen 2", v, 32'h0F0F000F);
    wr(8'h28, 32'h1234ABC0); rd(8'h28, v); check("R8 mgen 3", v, 32'hFFFFFFF0);
    wr(8'h28, 32'h00000000); rd(8'h28, v); check("R8 mgen 4", v, 32'h00000000);

    // R9 writes to read-only registers change nothing
    wr(8'h18, 32'h87654321);
    wr(8'h1C, 32'h1);
    wr(8'h20, 32'hFFFFFFFF);
    wr(8'h24, 32'h5A5A5A5A);
    rd(8'h18, v); check("R9 shift kept", v, 32'h08765432);
    rd(8'h20, v); check("R9 smask kept", v, 32'h0FFFFFFF);
    rd(8'h24, v); check("R9 spill kept", v, 32'h10000000);
    rd(8'h1C, v); check("R9 count reads zero", v, 32'h0);
    rd(8'h00, v); check("R9 unmapped zero", v, 32'h0);
    rd(8'h19, v); check("R9 unaligned zero", v, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule